// File: doc/BRIEF.md
# Serial Command Decoder for a Multichannel Receiver

This block is the serial slave that sits between a host controller and the per-channel storage of a multichannel word receiver. The host lowers chip select, clocks in one instruction byte MSB first, and then either sends a data field or reads one back on the same clock. The upper half of the instruction byte names a channel (1 to `NCH`); the lower half picks the operation. The data field is 16, 32 or 128 bits long, depending on the operation.

The block oversamples the serial clock, select and data in its own system clock domain, which must run at least four times faster than the serial clock. Its outputs are one-cycle action pulses carrying a channel index and the captured data: control-word write, label-table load, transmit-word load at either rate, master reset, and FIFO pop. Its inputs are the storage read ports: control words, label tables, FIFO heads and FIFO flags.

The FIFO read side works as a stream. `fifo_valid[n]` is the channel's valid (not empty) and `fifo_pop[n]` is the consumer's acceptance. A pop is issued only for a word that was valid when the read began, and only after the host has clocked out all of it, so a short read applies no back-pressure and loses nothing. Clearing a channel's FIFO on a control write is the storage's job, triggered by `ctl_we`.

Top module: `spicmd_decoder`

## Requirements
- R1: After `cs_n` falls, the first 8 rising `sck` edges capture the instruction byte MSB first. Bits 7:4 are the channel number (n = 1..NCH, reported as index n-1 on `wr_chan`). Bits 3:0 are the opcode.
- R2: Opcode 4 with a valid channel takes 16 data bits, first bit into bit 15. It then pulses `ctl_we` for one cycle with `wr_chan` and `ctl_wdata`.
- R3: Opcode 1 with a valid channel takes 128 bits, first bit into bit 127, and then pulses `lbl_we` with `lbl_wdata`.
- R4: Opcodes 8 and 9 take 32 bits and pulse `tx_we`, with `tx_fast` = 1 for opcode 8 and 0 for opcode 9. The channel nibble is ignored.
- R5: Opcode 7 pulses `mreset` for one cycle right after the instruction byte, whatever the channel nibble holds.
- R6: For a read, the field's MSB is on `so` from the first `sck` falling edge after the instruction byte. Opcode 5 returns the channel's 16-bit control word with bits 15:10 as 0. Opcode 2 returns its 128-bit label image.
- R7: Opcode 6 returns a 16-bit status word and ignores the channel nibble. Bit i (i = 0..7) is 1 when channel i+1 is empty (`fifo_valid` low). Bit 8+i is `fifo_full` of channel i+1.
- R8: Opcode 3 returns the channel's 32-bit FIFO head. After the 32nd data edge it pulses that channel's `fifo_pop` bit once. If the FIFO was empty when the read began, the field reads all zeros and no pop occurs.
- R9: If `cs_n` rises before the field is complete, the frame is discarded: no write pulse and no pop. The next frame decodes normally.
- R10: Opcodes 0 and A to F have no effect. A channel-specific opcode with channel nibble 0 or above NCH has no effect, and its read field is all zeros.
- R11: `so_oe` is low whenever `cs_n` is high and high while it is low.
- R12: At most one action output (`ctl_we`, `lbl_we`, `tx_we`, `mreset`, any `fifo_pop`) is high in a cycle, and each pulse lasts one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 4x `sck` |
| rst_n | input | 1 | Asynchronous active-low reset |
| sck | input | 1 | Serial clock from host |
| cs_n | input | 1 | Active-low frame select |
| si | input | 1 | Serial data in |
| so | output | 1 | Serial data out |
| so_oe | output | 1 | Output enable for the `so` pad (low = high impedance) |
| ctl_rdata | input | NCH*16 | Control words, channel n at slice n-1 |
| lbl_rdata | input | NCH*128 | Label images, channel n at slice n-1 |
| fifo_rdata | input | NCH*32 | FIFO head words |
| fifo_valid | input | NCH | FIFO not empty, per channel |
| fifo_full | input | NCH | FIFO full, per channel |
| fifo_pop | output | NCH | One-cycle pop per channel |
| ctl_we | output | 1 | Control word write pulse |
| lbl_we | output | 1 | Label table load pulse |
| tx_we | output | 1 | Transmit word load pulse |
| tx_fast | output | 1 | High rate for this transmit load |
| wr_chan | output | clog2(NCH) | Channel index of a write |
| ctl_wdata | output | 16 | Control word to write |
| lbl_wdata | output | 128 | Label image to load |
| tx_wdata | output | 32 | Transmit word to load |
| mreset | output | 1 | Master reset pulse |

## Verification
The bench uses the defaults: eight channels and a two-stage synchronizer, with the serial clock at twelve system clocks per period. With eight channels the nibble values 9 to F are out of range, so the invalid-channel path can be reached, and channel 8 shows the top index. It also fills the status word completely, so every empty and full position is checked. The 128-bit label field drives the bit counter to its full width, and two aborted frames (one write, one FIFO read) show that nothing is committed early.

// File: rtl/spicmd_pkg.sv
package spicmd_pkg;
  localparam int OPC_BITS  = 8;
  localparam int CTL_BITS  = 16;
  localparam int CTL_USED  = 10;
  localparam int WORD_BITS = 32;
  localparam int LBL_COUNT = 16;
  localparam int LBL_BITS  = LBL_COUNT * 8;
  localparam int STAT_BITS = 16;
  localparam int STAT_HALF = STAT_BITS / 2;
  localparam int CNT_W     = $clog2(LBL_BITS);

  localparam logic [3:0] OP_LBL_WR = 4'h1;
  localparam logic [3:0] OP_LBL_RD = 4'h2;
  localparam logic [3:0] OP_POP    = 4'h3;
  localparam logic [3:0] OP_CTL_WR = 4'h4;
  localparam logic [3:0] OP_CTL_RD = 4'h5;
  localparam logic [3:0] OP_STAT   = 4'h6;
  localparam logic [3:0] OP_MRST   = 4'h7;
  localparam logic [3:0] OP_TX_HI  = 4'h8;
  localparam logic [3:0] OP_TX_LO  = 4'h9;

  typedef enum logic [1:0] {ST_OPC, ST_WR, ST_RD, ST_DONE} fst_e;

  function automatic int field_len(input logic [3:0] op);
    case (op)
      OP_LBL_WR, OP_LBL_RD:         return LBL_BITS;
      OP_POP, OP_TX_HI, OP_TX_LO:   return WORD_BITS;
      OP_CTL_WR, OP_CTL_RD, OP_STAT: return CTL_BITS;
      default:                      return 1;
    endcase
  endfunction

  function automatic logic is_wr(input logic [3:0] op);
    return (op == OP_LBL_WR) || (op == OP_CTL_WR) || (op == OP_TX_HI) || (op == OP_TX_LO);
  endfunction

  function automatic logic is_rd(input logic [3:0] op);
    return (op == OP_LBL_RD) || (op == OP_POP) || (op == OP_CTL_RD) || (op == OP_STAT);
  endfunction
endpackage

// File: rtl/spicmd_sync.sv
module spicmd_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sck,
  input  logic cs_n,
  input  logic si,
  output logic sck_rise,
  output logic sck_fall,
  output logic cs_idle,
  output logic si_s
);
  logic [STAGES-1:0] sck_q, cs_q, si_q;
  logic              sck_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sck_q <= '0;
      cs_q  <= '1;
      si_q  <= '0;
      sck_d <= 1'b0;
    end else begin
      sck_q[0] <= sck;
      cs_q[0]  <= cs_n;
      si_q[0]  <= si;
      for (int k = 1; k < STAGES; k++) begin
        sck_q[k] <= sck_q[k-1];
        cs_q[k]  <= cs_q[k-1];
        si_q[k]  <= si_q[k-1];
      end
      sck_d <= sck_q[STAGES-1];
    end
  end

  assign sck_rise = sck_q[STAGES-1] & ~sck_d;
  assign sck_fall = ~sck_q[STAGES-1] & sck_d;
  assign cs_idle  = cs_q[STAGES-1];
  assign si_s     = si_q[STAGES-1];
endmodule

// File: rtl/spicmd_frame.sv
module spicmd_frame
  import spicmd_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                sck_rise,
  input  logic                sck_fall,
  input  logic                cs_idle,
  input  logic                si_s,
  input  logic [LBL_BITS-1:0] rd_word,
  output logic [3:0]          op_q,
  output logic [3:0]          chan_q,
  output logic                opc_done,
  output logic                fld_done,
  output logic [LBL_BITS-1:0] wdata,
  output logic                so_q
);
  fst_e                  st;
  logic [CNT_W-1:0]      cnt;
  logic [OPC_BITS-2:0]   osr;
  logic [LBL_BITS-1:0]   rsr;
  logic [OPC_BITS-1:0]   opc_byte;
  logic [CNT_W-1:0]      last_idx;

  assign opc_byte = {osr, si_s};
  assign last_idx = CNT_W'(field_len(op_q) - 1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= ST_OPC;
      cnt      <= '0;
      osr      <= '0;
      rsr      <= '0;
      wdata    <= '0;
      op_q     <= '0;
      chan_q   <= '0;
      opc_done <= 1'b0;
      fld_done <= 1'b0;
      so_q     <= 1'b0;
    end else begin
      opc_done <= 1'b0;
      fld_done <= 1'b0;
      // read image is taken the cycle after the opcode byte is decoded
      if (opc_done && is_rd(op_q)) rsr <= rd_word;
      if (cs_idle) begin
        st   <= ST_OPC;
        cnt  <= '0;
        so_q <= 1'b0;
      end else begin
        if (sck_rise) begin
          case (st)
            ST_OPC: begin
              osr <= opc_byte[OPC_BITS-2:0];
              if (cnt == CNT_W'(OPC_BITS - 1)) begin
                chan_q   <= opc_byte[7:4];
                op_q     <= opc_byte[3:0];
                opc_done <= 1'b1;
                cnt      <= '0;
                if (is_wr(opc_byte[3:0]))      st <= ST_WR;
                else if (is_rd(opc_byte[3:0])) st <= ST_RD;
                else                           st <= ST_DONE;
              end else begin
                cnt <= cnt + 1'b1;
              end
            end
            ST_WR: begin
              wdata <= {wdata[LBL_BITS-2:0], si_s};
              if (cnt == last_idx) begin
                fld_done <= 1'b1;
                st       <= ST_DONE;
              end else begin
                cnt <= cnt + 1'b1;
              end
            end
            ST_RD: begin
              if (cnt == last_idx) begin
                fld_done <= 1'b1;
                st       <= ST_DONE;
              end else begin
                cnt <= cnt + 1'b1;
              end
            end
            default: ;
          endcase
        end
        if (sck_fall) begin
          if (st == ST_RD) begin
            so_q <= rsr[LBL_BITS-1];
            rsr  <= {rsr[LBL_BITS-2:0], 1'b0};
          end else begin
            so_q <= 1'b0;
          end
        end
      end
    end
  end
endmodule

// File: rtl/spicmd_rdmux.sv
module spicmd_rdmux
  import spicmd_pkg::*;
#(
  parameter int NCH = 8
) (
  input  logic [3:0]               op,
  input  logic [3:0]               chan,
  input  logic [NCH*CTL_BITS-1:0]  ctl_rdata,
  input  logic [NCH*LBL_BITS-1:0]  lbl_rdata,
  input  logic [NCH*WORD_BITS-1:0] fifo_rdata,
  input  logic [NCH-1:0]           fifo_valid,
  input  logic [NCH-1:0]           fifo_full,
  output logic [LBL_BITS-1:0]      rd_word,
  output logic                     has_word
);
  localparam logic [CTL_BITS-1:0] CTL_MASK = CTL_BITS'((1 << CTL_USED) - 1);

  logic                 chan_ok;
  int                   idx;
  logic [STAT_BITS-1:0] stat;

  assign chan_ok = (chan >= 4'd1) && (int'(chan) <= NCH);
  assign idx     = int'(chan) - 1;

  always_comb begin
    stat = '0;
    for (int i = 0; i < STAT_HALF; i++) begin
      if (i < NCH) begin
        stat[i]             = ~fifo_valid[i];
        stat[STAT_HALF + i] = fifo_full[i];
      end
    end
  end

  always_comb begin
    rd_word  = '0;
    has_word = 1'b0;
    case (op)
      OP_LBL_RD: if (chan_ok) rd_word = lbl_rdata[idx*LBL_BITS +: LBL_BITS];
      OP_POP: begin
        if (chan_ok && fifo_valid[idx]) begin
          rd_word[LBL_BITS-1 -: WORD_BITS] = fifo_rdata[idx*WORD_BITS +: WORD_BITS];
          has_word = 1'b1;
        end
      end
      OP_CTL_RD: if (chan_ok) rd_word[LBL_BITS-1 -: CTL_BITS] = ctl_rdata[idx*CTL_BITS +: CTL_BITS] & CTL_MASK;
      OP_STAT:   rd_word[LBL_BITS-1 -: STAT_BITS] = stat;
      default: ;
    endcase
  end
endmodule

// File: rtl/spicmd_decoder.sv
module spicmd_decoder
  import spicmd_pkg::*;
#(
  parameter int NCH         = 8,
  parameter int SYNC_STAGES = 2,
  localparam int CHW        = (NCH > 1) ? $clog2(NCH) : 1
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     sck,
  input  logic                     cs_n,
  input  logic                     si,
  output logic                     so,
  output logic                     so_oe,
  input  logic [NCH*CTL_BITS-1:0]  ctl_rdata,
  input  logic [NCH*LBL_BITS-1:0]  lbl_rdata,
  input  logic [NCH*WORD_BITS-1:0] fifo_rdata,
  input  logic [NCH-1:0]           fifo_valid,
  input  logic [NCH-1:0]           fifo_full,
  output logic [NCH-1:0]           fifo_pop,
  output logic                     ctl_we,
  output logic                     lbl_we,
  output logic                     tx_we,
  output logic                     tx_fast,
  output logic [CHW-1:0]           wr_chan,
  output logic [CTL_BITS-1:0]      ctl_wdata,
  output logic [LBL_BITS-1:0]      lbl_wdata,
  output logic [WORD_BITS-1:0]     tx_wdata,
  output logic                     mreset
);
  logic                sck_rise, sck_fall, cs_idle, si_s;
  logic [3:0]          op_q, chan_q;
  logic                opc_done, fld_done;
  logic [LBL_BITS-1:0] wdata, rd_word;
  logic                has_word, pop_ok, so_q, chan_ok;

  spicmd_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .sck(sck), .cs_n(cs_n), .si(si),
    .sck_rise(sck_rise), .sck_fall(sck_fall), .cs_idle(cs_idle), .si_s(si_s)
  );

  spicmd_frame u_frame (
    .clk(clk), .rst_n(rst_n), .sck_rise(sck_rise), .sck_fall(sck_fall),
    .cs_idle(cs_idle), .si_s(si_s), .rd_word(rd_word), .op_q(op_q),
    .chan_q(chan_q), .opc_done(opc_done), .fld_done(fld_done),
    .wdata(wdata), .so_q(so_q)
  );

  spicmd_rdmux #(.NCH(NCH)) u_rdmux (
    .op(op_q), .chan(chan_q), .ctl_rdata(ctl_rdata), .lbl_rdata(lbl_rdata),
    .fifo_rdata(fifo_rdata), .fifo_valid(fifo_valid), .fifo_full(fifo_full),
    .rd_word(rd_word), .has_word(has_word)
  );

  // remember whether the FIFO head was valid when the read image was taken
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                             pop_ok <= 1'b0;
    else if (opc_done && op_q == OP_POP)    pop_ok <= has_word;
  end

  assign chan_ok   = (chan_q >= 4'd1) && (int'(chan_q) <= NCH);
  assign wr_chan   = CHW'(chan_q - 4'd1);
  assign ctl_we    = fld_done && (op_q == OP_CTL_WR) && chan_ok;
  assign lbl_we    = fld_done && (op_q == OP_LBL_WR) && chan_ok;
  assign tx_we     = fld_done && ((op_q == OP_TX_HI) || (op_q == OP_TX_LO));
  assign tx_fast   = tx_we && (op_q == OP_TX_HI);
  assign mreset    = opc_done && (op_q == OP_MRST);
  assign ctl_wdata = wdata[CTL_BITS-1:0];
  assign lbl_wdata = wdata;
  assign tx_wdata  = wdata[WORD_BITS-1:0];
  assign so        = so_q;
  assign so_oe     = ~cs_n;

  for (genvar g = 0; g < NCH; g++) begin : g_pop
    assign fifo_pop[g] = fld_done && (op_q == OP_POP) && chan_ok && pop_ok &&
                         (chan_q == 4'(g + 1));
  end
endmodule

// File: rtl/spicmd_checker.sv
module spicmd_checker #(
  parameter int NCH = 8
) (
  input logic           clk,
  input logic           rst_n,
  input logic           cs_n,
  input logic           ctl_we,
  input logic           lbl_we,
  input logic           tx_we,
  input logic           mreset,
  input logic [NCH-1:0] fifo_pop
);
  logic any_act;
  assign any_act = ctl_we | lbl_we | tx_we | mreset | (|fifo_pop);

  assert_one_action_R12: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({ctl_we, lbl_we, tx_we, mreset, |fifo_pop}));

  assert_single_pop_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(fifo_pop));

  assert_pulse_width_R12: assert property (@(posedge clk) disable iff (!rst_n)
    any_act |=> !any_act);

  assert_idle_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_n && $past(cs_n) && $past(cs_n, 2) && $past(cs_n, 3)) |-> !any_act);
endmodule

bind spicmd_decoder spicmd_checker #(.NCH(NCH)) u_chk (
  .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .ctl_we(ctl_we), .lbl_we(lbl_we),
  .tx_we(tx_we), .mreset(mreset), .fifo_pop(fifo_pop)
);

// File: tb/spicmd_decoder_bench.sv
module spicmd_decoder_bench;
  localparam int NCH  = 8;
  localparam int HALF = 6;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic rst_n = 1'b0, sck = 1'b0, cs_n = 1'b1, si = 1'b0;
  logic so, so_oe, ctl_we, lbl_we, tx_we, tx_fast, mreset;
  logic [NCH*16-1:0]  ctl_rdata = '0;
  logic [NCH*128-1:0] lbl_rdata = '0;
  logic [NCH*32-1:0]  fifo_rdata = '0;
  logic [NCH-1:0]     fifo_valid = '0, fifo_full = '0, fifo_pop;
  logic [2:0]         wr_chan;
  logic [15:0]        ctl_wdata;
  logic [127:0]       lbl_wdata;
  logic [31:0]        tx_wdata;

  spicmd_decoder u_spicmd_decoder (
    .clk(clk), .rst_n(rst_n), .sck(sck), .cs_n(cs_n), .si(si), .so(so), .so_oe(so_oe),
    .ctl_rdata(ctl_rdata), .lbl_rdata(lbl_rdata), .fifo_rdata(fifo_rdata),
    .fifo_valid(fifo_valid), .fifo_full(fifo_full), .fifo_pop(fifo_pop),
    .ctl_we(ctl_we), .lbl_we(lbl_we), .tx_we(tx_we), .tx_fast(tx_fast),
    .wr_chan(wr_chan), .ctl_wdata(ctl_wdata), .lbl_wdata(lbl_wdata),
    .tx_wdata(tx_wdata), .mreset(mreset)
  );

  int n_vec = 0, n_bad = 0;
  int n_act = 0, n_ctl = 0, n_lbl = 0, n_tx = 0, n_mr = 0, n_multi = 0, n_wide = 0;
  int n_pop [NCH];
  logic [2:0]   l_chan;
  logic [15:0]  l_ctl;
  logic [127:0] l_lbl;
  logic [31:0]  l_tx;
  logic         l_fast, prev_any = 1'b0;

  initial for (int i = 0; i < NCH; i++) n_pop[i] = 0;

  always @(negedge clk) begin
    if (rst_n) begin
      int a;
      a = int'(ctl_we) + int'(lbl_we) + int'(tx_we) + int'(mreset) + $countones(fifo_pop);
      if (a > 1) n_multi++;
      if (a > 0 && prev_any) n_wide++;
      prev_any = (a > 0);
      n_act += a;
      if (ctl_we) begin n_ctl++; l_chan = wr_chan; l_ctl = ctl_wdata; end
      if (lbl_we) begin n_lbl++; l_chan = wr_chan; l_lbl = lbl_wdata; end
      if (tx_we)  begin n_tx++;  l_tx = tx_wdata; l_fast = tx_fast; end
      if (mreset) n_mr++;
      for (int i = 0; i < NCH; i++) if (fifo_pop[i]) n_pop[i]++;
    end
  end

  task automatic check(input string req, input logic [127:0] act, input logic [127:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic xfer(input logic [7:0] opc, input int nbits, input logic [127:0] wbits,
                      input int stop, output logic [127:0] rbits);
    int total;
    total = (stop >= 0) ? stop : 8 + nbits;
    rbits = '0;
    cs_n = 1'b0;
    repeat (HALF) @(negedge clk);
    for (int i = 0; i < total; i++) begin
      si = (i < 8) ? opc[7-i] : wbits[127-(i-8)];
      repeat (HALF) @(negedge clk);
      if (i >= 8) rbits = {rbits[126:0], so};
      sck = 1'b1;
      repeat (HALF) @(negedge clk);
      sck = 1'b0;
    end
    repeat (HALF) @(negedge clk);
    cs_n = 1'b1;
    si = 1'b0;
    repeat (4*HALF) @(negedge clk);
  endtask

  task automatic t_reset;
    check("R11 so_oe idle after reset", 128'(so_oe), 128'(0));
    check("R12 no action after reset", 128'(n_act), 128'(0));
  endtask

  task automatic t_oe;
    cs_n = 1'b0;
    repeat (2) @(negedge clk);
    check("R11 so_oe while selected", 128'(so_oe), 128'(1));
    cs_n = 1'b1;
    @(negedge clk);
    check("R11 so_oe after deselect", 128'(so_oe), 128'(0));
    repeat (4*HALF) @(negedge clk);
  endtask

  task automatic t_ctl_write;
    logic [127:0] r;
    int c0, a0;
    c0 = n_ctl; a0 = n_act;
    xfer(8'h34, 16, {16'hA5C3, 112'b0}, -1, r);
    check("R2 ctl_we count", 128'(n_ctl - c0), 128'(1));
    check("R1 channel 3 index", 128'(l_chan), 128'(2));
    check("R2 control data", 128'(l_ctl), 128'(16'hA5C3));
    check("R12 single action", 128'(n_act - a0), 128'(1));
    xfer(8'h84, 16, {16'h0102, 112'b0}, -1, r);
    check("R1 channel 8 index", 128'(l_chan), 128'(7));
    check("R2 control data ch8", 128'(l_ctl), 128'(16'h0102));
  endtask

  task automatic t_ctl_read;
    logic [127:0] r;
    int a0;
    ctl_rdata = '1;
    ctl_rdata[4*16 +: 16] = 16'h1234;
    a0 = n_act;
    xfer(8'h25, 16, '0, -1, r);
    check("R6 control read masks bits 15:10", r[15:0], 128'(16'h03FF));
    xfer(8'h55, 16, '0, -1, r);
    check("R6 control read ch5", r[15:0], 128'(16'h0234));
    check("R6 reads make no action", 128'(n_act - a0), 128'(0));
  endtask

  task automatic t_label;
    logic [127:0] r, p;
    int l0;
    for (int k = 0; k < 16; k++) p[127-8*k -: 8] = 8'(k*17 + 3);
    l0 = n_lbl;
    xfer(8'h51, 128, p, -1, r);
    check("R3 lbl_we count", 128'(n_lbl - l0), 128'(1));
    check("R3 label channel", 128'(l_chan), 128'(4));
    check("R3 label data", l_lbl, p);
    lbl_rdata[4*128 +: 128] = ~p;
    xfer(8'h52, 128, '0, -1, r);
    check("R6 label read", r, ~p);
  endtask

  task automatic t_status;
    logic [127:0] r;
    fifo_valid = 8'b1010_0110;
    fifo_full  = 8'b0100_0001;
    xfer(8'hF6, 16, '0, -1, r);
    check("R7 status word", r[15:0], 128'({8'b0100_0001, 8'b0101_1001}));
    fifo_valid = '0;
    fifo_full  = '0;
  endtask

  task automatic t_fifo;
    logic [127:0] r;
    int p5, p6, a0;
    fifo_valid[5] = 1'b1;
    fifo_rdata[5*32 +: 32] = 32'hDEADBEEF;
    fifo_rdata[6*32 +: 32] = 32'hFFFF0000;
    p5 = n_pop[5]; p6 = n_pop[6]; a0 = n_act;
    xfer(8'h63, 32, '0, -1, r);
    check("R8 FIFO head word", r[31:0], 128'(32'hDEADBEEF));
    check("R8 pop on channel 6", 128'(n_pop[5] - p5), 128'(1));
    check("R8 only one action", 128'(n_act - a0), 128'(1));
    xfer(8'h73, 32, '0, -1, r);
    check("R8 empty FIFO reads zero", r[31:0], 128'(0));
    check("R8 no pop when empty", 128'(n_pop[6] - p6), 128'(0));
  endtask

  task automatic t_tx;
    logic [127:0] r;
    int t0;
    t0 = n_tx;
    xfer(8'h08, 32, {32'h12345678, 96'b0}, -1, r);
    check("R4 tx_we count", 128'(n_tx - t0), 128'(1));
    check("R4 high rate flag", 128'(l_fast), 128'(1));
    check("R4 tx data", 128'(l_tx), 128'(32'h12345678));
    xfer(8'h99, 32, {32'h0F0F00FF, 96'b0}, -1, r);
    check("R4 low rate flag", 128'(l_fast), 128'(0));
    check("R4 tx data low rate", 128'(l_tx), 128'(32'h0F0F00FF));
  endtask

  task automatic t_mreset;
    logic [127:0] r;
    int m0, a0;
    m0 = n_mr; a0 = n_act;
    xfer(8'hC7, 0, '0, -1, r);
    check("R5 master reset pulse", 128'(n_mr - m0), 128'(1));
    check("R5 no other action", 128'(n_act - a0), 128'(1));
  endtask

  task automatic t_abort;
    logic [127:0] r;
    int a0, p5;
    a0 = n_act; p5 = n_pop[5];
    xfer(8'h14, 16, {16'hBEEF, 112'b0}, 8 + 10, r);
    check("R9 aborted write discarded", 128'(n_act - a0), 128'(0));
    fifo_valid[5] = 1'b1;
    xfer(8'h63, 32, '0, 8 + 20, r);
    check("R9 aborted read no pop", 128'(n_pop[5] - p5), 128'(0));
    fifo_valid[5] = 1'b0;
    xfer(8'h14, 16, {16'h5AA5, 112'b0}, -1, r);
    check("R9 next frame decodes", 128'(l_ctl), 128'(16'h5AA5));
    check("R9 next frame channel", 128'(l_chan), 128'(0));
  endtask

  task automatic t_noop;
    logic [127:0] r;
    int a0;
    a0 = n_act;
    fifo_valid = '1;
    xfer(8'h00, 0, '0, -1, r);
    xfer(8'h3A, 32, '1, -1, r);
    xfer(8'h04, 16, '1, -1, r);
    xfer(8'h94, 16, '1, -1, r);
    xfer(8'h93, 32, '0, -1, r);
    check("R10 bad channel FIFO read zero", r[31:0], 128'(0));
    xfer(8'h95, 16, '0, -1, r);
    check("R10 bad channel control read zero", r[15:0], 128'(0));
    check("R10 no actions", 128'(n_act - a0), 128'(0));
    fifo_valid = '0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_vec++;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_oe();
    t_ctl_write();
    t_ctl_read();
    t_label();
    t_status();
    t_fifo();
    t_tx();
    t_mreset();
    t_abort();
    t_noop();
    check("R12 no overlapping actions", 128'(n_multi), 128'(0));
    check("R12 one-cycle pulses", 128'(n_wide), 128'(0));
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule